// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, each cycle, whether a five-stage in-order 16-bit pipeline advances. The stages are fetch, decode, execute (EX), a floating-point stage (F) that every instruction passes through, and write-back (WB). There is no forwarding. The controller compares the registers the decode instruction reads against the destinations of valid instructions still in EX, F or WB. On a match it freezes fetch and decode and sends a bubble into EX. A bubble is an instruction whose valid bit is cleared, so it writes no register and changes no flag.

A conditional instruction also waits while any instruction ahead of it can still change the zero flag. A floating-point operation stays in F for two clocks. During its first clock the controller freezes everything behind F and sends a bubble into WB. When an instruction in WB writes register 15, the program counter, the controller raises `flush`. This squashes every younger stage and redirects fetch, and it overrides every stall.

The block carries no data stream. `hold_front` is the not-ready signal back to fetch and decode. The other outputs are plain per-stage controls that the pipeline registers obey in the same cycle.

Top module: `hz_stall_ctrl`

## Requirements
- R1: After reset, with no in-flight stage valid, `hold_front`, `bubble_ex`, `hold_ex`, `bubble_wb` and `flush` are all 0.
- R2: A valid decode instruction stalls when a valid, register-writing instruction in EX, F or WB (in-flight index 0, 1, 2) has a destination equal to a register it reads. A stall sets `hold_front`=1 and `bubble_ex`=1.
- R3: The second-argument field `dec_src` counts as a read only when `dec_src_is_reg`=1. When it holds a constant (0), a match on its value causes no stall.
- R4: The destination field `dec_dst` counts as a read only when `dec_rmw`=1.
- R5: In-flight instructions that are invalid, or that do not write a register, never cause a stall. An invalid decode slot never causes a data or flag stall.
- R6: A valid decode instruction with condition code other than 2'b00 (00 = always execute) stalls while any valid in-flight instruction has `fl_sets_flag` set.
- R7: In the first clock that a valid floating-point op occupies F, `hold_front`=1, `hold_ex`=1, `bubble_wb`=1 and `bubble_ex`=0. In its second clock these are released unless another hazard holds.
- R8: A valid register write to register 15 in WB gives `flush`=1. In that cycle `hold_front`, `bubble_ex`, `hold_ex` and `bubble_wb` are 0.
- R9: A floating-point op that enters F after an earlier one finished, or after a flush, again gets two clocks, starting with a frozen one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_dst | input | REG_W | Destination field of the decode instruction |
| dec_rmw | input | 1 | Destination is also read |
| dec_src | input | REG_W | Second-argument field |
| dec_src_is_reg | input | 1 | Second argument names a register |
| dec_cond | input | 2 | Condition code, 00 = always |
| fl_valid | input | N_FL | Valid per in-flight stage (0 EX, 1 F, 2 WB) |
| fl_wr | input | N_FL | Stage writes a register |
| fl_sets_flag | input | N_FL | Stage may update the zero flag |
| fl_dst | input | N_FL*REG_W | Destinations, stage k at bits k*REG_W upward |
| fx_is_fp | input | 1 | Instruction in F is floating-point |
| hold_front | output | 1 | Freeze fetch and decode |
| bubble_ex | output | 1 | Load a bubble into EX |
| hold_ex | output | 1 | Freeze EX and F |
| bubble_wb | output | 1 | Load a bubble into WB |
| flush | output | 1 | Squash younger stages and redirect fetch |

## Verification
The bench sweeps every combination of in-flight valid and write bits, decode selectors and condition, and the flag producer. It uses destination patterns that hit and miss both decode fields and put register 15 in WB. A design that ignored the register selector or the read-modify-write bit would stall on constants or on pure destinations. One that did not gate on valid or write bits would leave bubbles in the pipeline for no reason. A flush that failed to override a stall would freeze a squashed pipeline. Directed sequences check that a floating-point op freezes for exactly one clock, that back-to-back ops each get their own frozen clock, and that a flush restarts the two-clock count. Errors there show up as a hold that never ends, a hold that never comes back, or a hold that is skipped.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef logic [1:0] cond_t;
  localparam cond_t COND_ALWAYS = 2'b00;
  localparam int IDX_EX = 0;
  localparam int IDX_FX = 1;
  localparam int IDX_WB = 2;
endpackage

// File: rtl/hz_stage_cmp.sv
module hz_stage_cmp #(
  parameter int REG_W = 4
) (
  input  logic             valid,
  input  logic             wr,
  input  logic             sets_flag,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] rd_a,
  input  logic             rd_a_en,
  input  logic [REG_W-1:0] rd_b,
  input  logic             rd_b_en,
  input  logic             needs_flag,
  output logic             data_hit,
  output logic             flag_hit
);
  logic writer;
  always_comb begin
    writer   = valid & wr;
    data_hit = writer & ((rd_a_en & (dst == rd_a)) | (rd_b_en & (dst == rd_b)));
    flag_hit = valid & sets_flag & needs_flag;
  end
endmodule

// File: rtl/hz_fp_timer.sv
module hz_fp_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic f_valid,
  input  logic f_is_fp,
  input  logic squash,
  output logic busy
);
  logic done_q;
  always_comb busy = f_valid & f_is_fp & ~done_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= busy & ~squash;
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int N_FL   = 3,
  parameter int PC_IDX = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_valid,
  input  logic [REG_W-1:0]      dec_dst,
  input  logic                  dec_rmw,
  input  logic [REG_W-1:0]      dec_src,
  input  logic                  dec_src_is_reg,
  input  logic [1:0]            dec_cond,
  input  logic [N_FL-1:0]       fl_valid,
  input  logic [N_FL-1:0]       fl_wr,
  input  logic [N_FL-1:0]       fl_sets_flag,
  input  logic [N_FL*REG_W-1:0] fl_dst,
  input  logic                  fx_is_fp,
  output logic                  hold_front,
  output logic                  bubble_ex,
  output logic                  hold_ex,
  output logic                  bubble_wb,
  output logic                  flush
);
  localparam int WB_LO = IDX_WB * REG_W;
  localparam logic [REG_W-1:0] PC_REG = REG_W'(PC_IDX);

  logic [N_FL-1:0] data_hit, flag_hit;
  logic needs_flag, dep, fp_busy;

  always_comb needs_flag = (cond_t'(dec_cond) != COND_ALWAYS);

  for (genvar s = 0; s < N_FL; s++) begin : g_stage
    hz_stage_cmp #(.REG_W(REG_W)) u_cmp (
      .valid      (fl_valid[s]),
      .wr         (fl_wr[s]),
      .sets_flag  (fl_sets_flag[s]),
      .dst        (fl_dst[s*REG_W +: REG_W]),
      .rd_a       (dec_dst),
      .rd_a_en    (dec_rmw),
      .rd_b       (dec_src),
      .rd_b_en    (dec_src_is_reg),
      .needs_flag (needs_flag),
      .data_hit   (data_hit[s]),
      .flag_hit   (flag_hit[s])
    );
  end

  always_comb begin
    flush = fl_valid[IDX_WB] & fl_wr[IDX_WB] & (fl_dst[WB_LO +: REG_W] == PC_REG);
    dep   = dec_valid & ((|data_hit) | (|flag_hit));
  end

  hz_fp_timer u_fp (
    .clk     (clk),
    .rst_n   (rst_n),
    .f_valid (fl_valid[IDX_FX]),
    .f_is_fp (fx_is_fp),
    .squash  (flush),
    .busy    (fp_busy)
  );

  always_comb begin
    hold_front = (dep | fp_busy) & ~flush;
    hold_ex    = fp_busy & ~flush;
    bubble_wb  = fp_busy & ~flush;
    bubble_ex  = dep & ~fp_busy & ~flush;
  end
endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
  parameter int N_FL = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            dec_rmw,
  input logic            dec_src_is_reg,
  input logic [1:0]      dec_cond,
  input logic [N_FL-1:0] fl_valid,
  input logic            fx_is_fp,
  input logic            hold_front,
  input logic            bubble_ex,
  input logic            hold_ex,
  input logic            bubble_wb,
  input logic            flush
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid == '0) |-> (!hold_front && !bubble_ex && !hold_ex && !bubble_wb && !flush));

  p_bubble_with_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> hold_front);

  p_const_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_src_is_reg && !dec_rmw && dec_cond == 2'b00 && !(fl_valid[1] && fx_is_fp))
      |-> !hold_front);

  p_fp_one_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ex |=> !hold_ex);

  p_ex_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bubble_ex && hold_ex));

  p_flush_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!hold_front && !bubble_ex && !hold_ex && !bubble_wb));
endmodule

bind hz_stall_ctrl hz_stall_chk #(.N_FL(N_FL)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_rmw(dec_rmw),
  .dec_src_is_reg(dec_src_is_reg), .dec_cond(dec_cond), .fl_valid(fl_valid),
  .fx_is_fp(fx_is_fp), .hold_front(hold_front), .bubble_ex(bubble_ex),
  .hold_ex(hold_ex), .bubble_wb(bubble_wb), .flush(flush)
);

// File: tb/test_hz_stall_ctrl.sv
module test_hz_stall_ctrl;
  localparam int REG_W = 4;
  localparam int N_FL  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid, dec_rmw, dec_src_is_reg, fx_is_fp;
  logic [REG_W-1:0] dec_dst, dec_src;
  logic [1:0] dec_cond;
  logic [N_FL-1:0] fl_valid, fl_wr, fl_sets_flag;
  logic [N_FL*REG_W-1:0] fl_dst;
  logic hold_front, bubble_ex, hold_ex, bubble_wb, flush;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hz_stall_ctrl #(.REG_W(REG_W), .N_FL(N_FL), .PC_IDX(15)) i_hz_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_dst(dec_dst),
    .dec_rmw(dec_rmw), .dec_src(dec_src), .dec_src_is_reg(dec_src_is_reg),
    .dec_cond(dec_cond), .fl_valid(fl_valid), .fl_wr(fl_wr),
    .fl_sets_flag(fl_sets_flag), .fl_dst(fl_dst), .fx_is_fp(fx_is_fp),
    .hold_front(hold_front), .bubble_ex(bubble_ex), .hold_ex(hold_ex),
    .bubble_wb(bubble_wb), .flush(flush)
  );

  // packed as {hold_front, bubble_ex, hold_ex, bubble_wb, flush}
  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {hold_front, bubble_ex, hold_ex, bubble_wb, flush};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_valid = 0; dec_rmw = 0; dec_src_is_reg = 0; dec_dst = 0; dec_src = 0;
    dec_cond = 0; fl_valid = 0; fl_wr = 0; fl_sets_flag = 0; fl_dst = 0; fx_is_fp = 0;
  endtask

  function automatic logic [REG_W-1:0] pick(input int k);
    case (k % 4)
      0: return 4'd1;
      1: return 4'd2;
      2: return 4'd3;
      default: return 4'd15;
    endcase
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset idle", 5'b00000);

    // directed R3: constant second argument equal to an in-flight destination
    @(negedge clk);
    idle(); dec_valid = 1; dec_src = 4'd4; dec_src_is_reg = 0;
    fl_valid = 3'b001; fl_wr = 3'b001; fl_dst = {4'd0, 4'd0, 4'd4};
    #1 check("R3 constant ignored", 5'b00000);
    dec_src_is_reg = 1;
    #1 check("R2/R3 register read stalls", 5'b11000);
    // R4: destination read only under rmw
    dec_src_is_reg = 0; dec_dst = 4'd4;
    #1 check("R4 pure destination", 5'b00000);
    dec_rmw = 1;
    #1 check("R4 rmw destination", 5'b11000);
    // R5: writer not valid / no write
    fl_valid = 3'b000;
    #1 check("R5 invalid writer", 5'b00000);
    fl_valid = 3'b001; fl_wr = 3'b000;
    #1 check("R5 non-writing", 5'b00000);
    fl_wr = 3'b001; dec_valid = 0;
    #1 check("R5 invalid decode", 5'b00000);
    // R6: flag dependency
    idle(); dec_valid = 1; dec_cond = 2'b10; fl_valid = 3'b100; fl_sets_flag = 3'b100;
    #1 check("R6 conditional waits for flag", 5'b11000);
    dec_cond = 2'b00;
    #1 check("R6 unconditional proceeds", 5'b00000);

    // sweep R2 R3 R4 R5 R6 R8
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 2048; i++) begin
        logic [10:0] b;
        logic dep, fl;
        logic [4:0] exp;
        @(negedge clk);
        b = 11'(i);
        idle();
        fl_valid = b[2:0]; fl_wr = b[5:3];
        fl_sets_flag = b[6] ? N_FL'(1 << (p % 3)) : '0;
        dec_rmw = b[7]; dec_src_is_reg = b[8]; dec_valid = b[9];
        dec_cond = b[10] ? 2'(p % 3 + 1) : 2'b00;
        dec_dst = 4'd1; dec_src = 4'd2;
        for (int s = 0; s < N_FL; s++) fl_dst[s*REG_W +: REG_W] = pick(p + s);
        dep = 0;
        for (int s = 0; s < N_FL; s++) begin
          logic [REG_W-1:0] d;
          d = pick(p + s);
          if (fl_valid[s] && fl_wr[s] && ((dec_rmw && d == 4'd1) || (dec_src_is_reg && d == 4'd2)))
            dep = 1;
          if (fl_valid[s] && fl_sets_flag[s] && dec_cond != 2'b00) dep = 1;
        end
        dep = dep && dec_valid;
        fl = fl_valid[2] && fl_wr[2] && pick(p + 2) == 4'd15;
        exp = fl ? 5'b00001 : (dep ? 5'b11000 : 5'b00000);
        #1 check("R2/R3/R4/R5/R6/R8 sweep", exp);
      end
    end

    // floating-point timing R7 R9 R8
    @(negedge clk); idle();
    rst_n = 0; @(posedge clk); rst_n = 1;
    @(negedge clk);
    fl_valid = 3'b010; fx_is_fp = 1;
    #1 check("R7 first fp clock frozen", 5'b10110);
    @(negedge clk); #1 check("R7 second fp clock released", 5'b00000);
    @(negedge clk); #1 check("R9 next fp frozen again", 5'b10110);
    @(negedge clk);
    dec_valid = 1; dec_src_is_reg = 1; dec_src = 4'd6;
    fl_valid = 3'b011; fl_wr = 3'b001; fl_dst = {4'd0, 4'd0, 4'd6};
    #1 check("R7 data hazard in fp release clock", 5'b11000);
    @(negedge clk);
    idle(); fl_valid = 3'b110; fx_is_fp = 1; fl_wr = 3'b100; fl_dst = {4'd15, 4'd0, 4'd0};
    #1 check("R8 flush overrides fp freeze", 5'b00001);
    @(negedge clk);
    fl_valid = 3'b010; fl_wr = 3'b000;
    #1 check("R9 fp after flush frozen", 5'b10110);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule